// File: doc/BRIEF.md
# Self-Timed SPI Pattern Master

This block is an SPI master that produces its own traffic and needs no host. On its own schedule it selects a slave, shifts out one byte, reads the byte the slave returns at the same time, releases the slave and waits before the next transfer. The byte it sends comes from an 8-bit pattern counter. The counter advances by one after every transfer, so a scope or a slave under test sees a steadily incrementing sequence.

The serial link runs in mode 0 and shifts the most significant bit first. The serial clock is derived from the system clock. One parameter sets the number of cycles in each clock phase. Guard intervals keep chip select low well before the first rising edge and well after the last falling edge. A third interval sets the idle time between transfers. When a transfer finishes, the block raises a one-cycle strobe. With the strobe it presents the captured byte and the byte that was sent, so that a checker can compare the two.

Enable starts generation and pauses it. A transfer that has already begun always finishes.

Top module: `spi_pattern_master`

## Requirements
- R1: While reset is high and just after it is released, chip select is high, the serial clock and serial output are low and the valid strobe is low. The first byte sent after reset is 0.
- R2: The serial clock is low whenever chip select is high.
- R3: Each chip-select-low window contains exactly 8 serial clock rising edges. The serial output, sampled at those edges, gives the sent byte most significant bit first.
- R4: The serial output does not change while the serial clock is high.
- R5: The first rising edge comes GUARD_CYC + HALF_CYC cycles after chip select falls.
- R6: Every high phase of the serial clock lasts HALF_CYC cycles. So does every low phase between two bits.
- R7: Chip select rises GUARD_CYC cycles after the last falling edge of the serial clock.
- R8: While enable stays high, chip select falls again IDLE_CYC + 1 cycles after it rose.
- R9: The byte sent increases by one per transfer, modulo 256 (255 is followed by 0).
- R10: The valid strobe is high for exactly one cycle, the cycle in which chip select rises. With it, the received byte output holds the 8 bits sampled from the serial input at the rising edges (first bit in bit 7), and the sent byte output holds the byte just sent.
- R11: With enable low, no new transfer starts. A transfer already in progress completes, and the pattern resumes from the next value when enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new transfers to start |
| sdi | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the slave |
| rx_valid | output | 1 | One-cycle strobe at the end of a transfer |
| rx_byte | output | DW | Byte captured from the slave |
| tx_byte | output | DW | Byte that was sent in that transfer |

## Verification
The bound checker enforces these rules on every cycle:
- the serial clock stays quiet while the slave is deselected;
- the output bit holds steady through each high phase;
- each high phase has the right length;
- the strobe is a single cycle, coinciding with the release of chip select;
- the sent byte steps by one from one strobe to the next.

Some properties can only be shown by the bench's scenarios. These are the exact guard and idle distances, the count of edges per window, the bit order on the wire and the agreement of the captured byte with what a modelled slave returned. The same holds for the wrap from 255 to 0 and for pausing in mid-transfer.

// File: rtl/spi_pat_pkg.sv
package spi_pat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } spi_st_e;
endpackage

// File: rtl/spi_dur_timer.sv
module spi_dur_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          capture,
  input  logic          sdi,
  output logic          sdo,
  output logic          last,
  output logic [DW-1:0] rx_data
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] tx_sh;
  logic [BW-1:0] bit_cnt;

  assign sdo  = tx_sh[DW-1];
  assign last = (bit_cnt == BW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      bit_cnt <= '0;
      rx_data <= '0;
    end else begin
      if (load) begin
        tx_sh   <= load_val;
        bit_cnt <= '0;
      end else if (shift) begin
        tx_sh   <= {tx_sh[DW-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (capture) rx_data <= {rx_data[DW-2:0], sdi};
    end
  end
endmodule

// File: rtl/spi_pattern_master.sv
module spi_pattern_master #(
  parameter int DW        = 8,
  parameter int HALF_CYC  = 25,
  parameter int GUARD_CYC = 200,
  parameter int IDLE_CYC  = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          sdi,
  output logic          cs_n,
  output logic          sclk,
  output logic          sdo,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic [DW-1:0] tx_byte
);
  import spi_pat_pkg::*;

  localparam int MAX_A = (HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC;
  localparam int MAX_L = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
  localparam int CW    = $clog2(MAX_L + 1);

  spi_st_e       st;
  logic [CW-1:0] limit;
  logic          done;
  logic          last;
  logic [DW-1:0] pattern;
  logic [DW-1:0] rx_data;
  logic          start;

  assign start = (st == ST_IDLE) && enable;

  always_comb begin
    case (st)
      ST_SETUP, ST_HOLD: limit = CW'(GUARD_CYC);
      ST_LOW, ST_HIGH:   limit = CW'(HALF_CYC);
      ST_GAP:            limit = CW'(IDLE_CYC);
      default:           limit = CW'(1);
    endcase
  end

  spi_dur_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   ((st == ST_IDLE) || done),
    .limit (limit),
    .done  (done)
  );

  spi_shift_engine #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (pattern),
    .shift    ((st == ST_HIGH) && done && !last),
    .capture  ((st == ST_LOW) && done),
    .sdi      (sdi),
    .sdo      (sdo),
    .last     (last),
    .rx_data  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      tx_byte  <= '0;
      pattern  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: if (enable) begin
          cs_n <= 1'b0;
          st   <= ST_SETUP;
        end
        ST_SETUP: if (done) st <= ST_LOW;
        ST_LOW: if (done) begin
          sclk <= 1'b1;
          st   <= ST_HIGH;
        end
        ST_HIGH: if (done) begin
          sclk <= 1'b0;
          st   <= last ? ST_HOLD : ST_LOW;
        end
        ST_HOLD: if (done) begin
          cs_n     <= 1'b1;
          rx_valid <= 1'b1;
          rx_byte  <= rx_data;
          tx_byte  <= pattern;
          pattern  <= pattern + 1'b1;
          st       <= ST_GAP;
        end
        ST_GAP: if (done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pattern_master_chk.sv
module spi_pattern_master_chk #(
  parameter int DW       = 8,
  parameter int HALF_CYC = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sclk,
  input logic          sdo,
  input logic          rx_valid,
  input logic [DW-1:0] tx_byte
);
  logic [15:0]   hi_run;
  logic [DW-1:0] prev_tx;
  logic [DW-1:0] next_tx;
  logic          have_prev;

  assign next_tx = prev_tx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run    <= '0;
      prev_tx   <= '0;
      have_prev <= 1'b0;
    end else begin
      hi_run <= sclk ? hi_run + 1'b1 : '0;
      if (rx_valid) begin
        prev_tx   <= tx_byte;
        have_prev <= 1'b1;
      end
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_sdo_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

  assert_high_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_run == 16'(HALF_CYC)));

  assert_pattern_step_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && have_prev) |-> (tx_byte == next_tx));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_at_release_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cs_n && !$past(cs_n)));
endmodule

bind spi_pattern_master spi_pattern_master_chk #(
  .DW(DW), .HALF_CYC(HALF_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .sdo      (sdo),
  .rx_valid (rx_valid),
  .tx_byte  (tx_byte)
);

// File: tb/sim_spi_pattern_master.sv
module sim_spi_pattern_master;
  localparam int H = 2;
  localparam int G = 3;
  localparam int I = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sdi = 1'b0;
  logic cs_n, sclk, sdo, rx_valid;
  logic [7:0] rx_byte, tx_byte;

  int total = 0, fails = 0;
  int cyc = 0, k = 0, falls = 0, nrise = 0;
  int t_fall = 0, t_sr = 0, t_sf = 0, t_csr = 0;
  bit run = 0, gap_chk = 1, have_rel = 0, done_flag = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;
  logic [7:0] mon = '0;
  logic [7:0] slv = '0;

  always #10 clk = ~clk;

  spi_pattern_master #(.DW(8), .HALF_CYC(H), .GUARD_CYC(G), .IDLE_CYC(I)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] resp(input int n);
    return 8'((n * 37 + 11) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // slave model: first bit at select, next bit at each falling clock edge
  always @(negedge cs_n) begin
    slv = resp(k);
    sdi = slv[7];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      slv = {slv[6:0], 1'b0};
      sdi = slv[7];
    end
  end

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      if (p_cs && !cs_n) begin
        if (gap_chk && have_rel) chk(cyc - t_csr == I + 1, "R8", cyc - t_csr, I + 1);
        t_fall = cyc; nrise = 0; mon = '0; falls++;
      end
      if (!p_sclk && sclk) begin
        if (nrise == 0) chk(cyc - t_fall == G + H, "R5", cyc - t_fall, G + H);
        else            chk(cyc - t_sf == H, "R6", cyc - t_sf, H);
        mon = {mon[6:0], sdo}; nrise++; t_sr = cyc;
      end
      if (p_sclk && !sclk) begin
        chk(cyc - t_sr == H, "R6", cyc - t_sr, H);
        chk(p_sdo == mon[0], "R4", p_sdo, mon[0]);
        t_sf = cyc;
      end
      if (!p_cs && cs_n) begin
        chk(cyc - t_sf == G, "R7", cyc - t_sf, G);
        chk(nrise == 8, "R3", nrise, 8);
        chk(mon == 8'(k % 256), "R9", mon, k % 256);
        chk(rx_valid == 1'b1, "R10", rx_valid, 1);
        chk(rx_byte == resp(k), "R10", rx_byte, resp(k));
        chk(tx_byte == 8'(k % 256), "R10", tx_byte, k % 256);
        k++; t_csr = cyc; have_rel = 1;
      end else if (rx_valid) begin
        chk(1'b0, "R10", 1, 0);
      end
      if (cs_n && sclk) chk(1'b0, "R2", sclk, 0);
      p_cs = cs_n; p_sclk = sclk; p_sdo = sdo;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int kp, fc;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R1", cs_n, 1);
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(sdo == 1'b0, "R1", sdo, 0);
    chk(rx_valid == 1'b0, "R1", rx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && sdo == 1'b0, "R1", cs_n, 1);
    run = 1;
    enable = 1'b1;
    // sweep through every pattern value and across the wrap
    while (k < 258) @(negedge clk);
    // pause in mid-transfer
    while (cs_n) @(negedge clk);
    enable = 1'b0;
    kp = k;
    while (k < kp + 1) @(negedge clk);
    fc = falls;
    repeat (200) @(negedge clk);
    chk(falls == fc, "R11", falls, fc);
    chk(cs_n == 1'b1, "R11", cs_n, 1);
    gap_chk = 0;
    enable = 1'b1;
    while (k < kp + 3) @(negedge clk);
    chk(k == kp + 3, "R11", k, kp + 3);
    finish_run();
  end
endmodule